// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the byte-level transaction sequencer of an I2C master. Software programs the slave address, an optional internal address of one to three bytes, and a command word that holds two transfer descriptors. After a start request the sequencer runs the whole transfer by itself. It sends START, the address byte, the internal-address bytes, and one or two data phases. It also sends STOP. STOP comes from a per-descriptor byte down-counter, so software never has to time it. A nonzero second descriptor chains a combined transfer through a repeated START.

The sequencer drives a bit-level engine through a request/done handshake, one operation at a time. Write data arrives on a valid/ready byte stream. Read data leaves as a one-cycle valid pulse. A NACK from the slave on any written byte aborts the transfer, forces STOP and sets an error flag.

Top module: `i2c_cmd_seq`

## Requirements
- R1: The register port has four selects: 0 = control, 1 = master mode, 2 = internal address, 3 = command word. In the control register, bit 0 requests a start, bit 16 enables the descriptor mode and bit 17 disables it (disable wins). A start request runs only if the mode is enabled and the first descriptor length is nonzero; otherwise it is ignored and no engine request is made.
- R2: In the command word, descriptor 0 has its length in bits [7:0], its direction in bit 8 (1 = read) and its PEC request in bit 9. Descriptor 1 uses bits [23:16], 24 and 25 in the same way. Each data phase moves exactly its length in bytes, from 1 to 255. With a zero second length the sequence is START, address, data, STOP.
- R3: With a nonzero second length, the first data phase is followed by a repeated START. The address is then sent again with descriptor 1's direction, then descriptor 1's data, then STOP. No STOP comes between the two phases.
- R4: Master mode holds the address in bits [6:0] and the internal-address size (0 to 3) in bits [9:8]. With a nonzero size, the address is first sent with the write bit. The internal address bytes follow, most significant first (byte k is bits [8k+7:8k]). A write descriptor then continues with data directly. A read descriptor inserts a repeated START and the address with the read bit.
- R5: Master mode bit 12, the legacy read flag, has no effect on the direction of any phase.
- R6: On reads, the master answers the last byte of a descriptor with NACK and all earlier bytes with ACK.
- R7: A slave NACK on an address, internal-address or data byte makes STOP the next operation. It also sets the error output until the next accepted start, and no further data moves.
- R8: The PEC request bits have no effect on the operation sequence.
- R9: Each data write byte is taken from the transmit stream only while it is valid, with exactly one ready pulse per byte.
- R10: Each received byte is presented once on the receive port with a one-cycle valid pulse, in order.
- R11: After reset the block is idle: no request, no error, not busy. Completion of STOP gives a one-cycle done pulse, and busy drops in that same cycle.
- R12: The engine operation code and byte stay stable while a request is pending. Operation codes: 0 START, 1 repeated START, 2 STOP, 3 write byte, 4 read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| tx_valid | input | 1 | Transmit byte available |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte taken (pulse) |
| rx_valid | output | 1 | Received byte valid (pulse) |
| rx_data | output | 8 | Received byte |
| eng_req | output | 1 | Operation request to bit engine |
| eng_op | output | 3 | Operation code |
| eng_wbyte | output | 8 | Byte to write |
| eng_mnack | output | 1 | Master answers NACK to this read byte |
| eng_done | input | 1 | Engine finished the operation (pulse) |
| eng_ack | input | 1 | Slave acknowledged the written byte |
| eng_rbyte | input | 8 | Byte read by the engine |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | Sequence finished (pulse) |
| seq_err | output | 1 | Sequence aborted by slave NACK |

## Verification
The assertions assume that the bit engine pulses done for a single cycle, and only while a request is pending. They also assume that the acknowledge input is meaningful only in that done cycle. The bench engine model follows this. It waits for a raised request, waits a random 0 to 2 cycles, then gives exactly one done pulse. Transmit valid is toggled at random only between edges, and register writes never overlap a running sequence.

// File: rtl/i2c_cmd_seq_pkg.sv
// Shared types for the I2C command sequencer.
// Assumes 8-bit bytes and 8-bit descriptor lengths.
package i2c_cmd_seq_pkg;
    localparam int LEN_W  = 8;
    localparam int BYTE_W = 8;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_MODE = 2'd1;
    localparam logic [1:0] SEL_IADR = 2'd2;
    localparam logic [1:0] SEL_CMD  = 2'd3;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } eng_op_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_ADDR, ST_IADR, ST_RESTART, ST_DATA, ST_STOP
    } seq_state_t;

    typedef struct packed {
        logic             pec;
        logic             rd;
        logic [LEN_W-1:0] len;
    } desc_t;
endpackage

// File: rtl/i2c_cmd_seq_regs.sv
// Register file: decodes the write port into mode enable, start pulse,
// address, internal-address size/value and the two descriptors.
// Assumes writes are single-cycle strobes; unused fields are dropped.
module i2c_cmd_seq_regs
    import i2c_cmd_seq_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int IADR_BYTES = 3,
    parameter int REG_W      = 32,
    parameter int D1_OFF     = 16,
    parameter int ISZ_OFF    = 8,
    parameter int ISZ_W      = $clog2(IADR_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [1:0]              sel,
    input  logic [REG_W-1:0]        wdata,
    output logic                    mode_en,
    output logic                    start_req,
    output logic [ADDR_W-1:0]       slave_addr,
    output logic [ISZ_W-1:0]        iadr_size,
    output logic [IADR_BYTES*8-1:0] iadr,
    output desc_t                   d0,
    output desc_t                   d1
);
    localparam int DESC_W  = LEN_W + 2;
    localparam int EN_BIT  = 16;
    localparam int DIS_BIT = 17;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // Control register: mode latch and start strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_en   <= 1'b0;
            start_req <= 1'b0;
        end else begin
            start_req <= we && (sel == SEL_CTRL) && wdata[0];
            if (we && (sel == SEL_CTRL)) begin
                if (wdata[DIS_BIT])     mode_en <= 1'b0;
                else if (wdata[EN_BIT]) mode_en <= 1'b1;
            end
        end
    end

    // Configuration registers: address, internal address, descriptors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slave_addr <= '0;
            iadr_size  <= '0;
            iadr       <= '0;
            d0         <= '0;
            d1         <= '0;
        end else if (we) begin
            case (sel)
                SEL_MODE: begin
                    slave_addr <= wdata[ADDR_W-1:0];
                    iadr_size  <= wdata[ISZ_OFF +: ISZ_W];
                end
                SEL_IADR: iadr <= wdata[IADR_BYTES*8-1:0];
                SEL_CMD: begin
                    d0 <= desc_t'(wdata[DESC_W-1:0]);
                    d1 <= desc_t'(wdata[D1_OFF +: DESC_W]);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cmd_seq_cnt.sv
// Loadable down-counter with a last-count flag.
// Assumes load has priority over decrement; it saturates at zero.
module i2c_cmd_seq_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         last
);
    assign last = (count == W'(1));

    // Count register: load or step down
    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= '0;
        else if (load)                count <= load_val;
        else if (dec && count != '0)  count <= count - W'(1);
    end
endmodule

// File: rtl/i2c_cmd_seq_fsm.sv
// Phase controller: walks START, address, internal address, data phases,
// repeated START and STOP, one engine request at a time.
// Assumes eng_done is a one-cycle pulse given only while eng_req is high.
module i2c_cmd_seq_fsm
    import i2c_cmd_seq_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int IADR_BYTES = 3,
    parameter int ISZ_W      = $clog2(IADR_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_en,
    input  logic                    start_req,
    input  logic [ADDR_W-1:0]       slave_addr,
    input  logic [IADR_BYTES*8-1:0] iadr,
    input  desc_t                   d0,
    input  desc_t                   d1,
    input  logic [LEN_W-1:0]        dcnt,
    input  logic                    dlast,
    input  logic [ISZ_W-1:0]        icnt,
    input  logic                    ilast,
    output logic                    go,
    output logic                    dload,
    output logic [LEN_W-1:0]        dval,
    output logic                    ddec,
    output logic                    idec,
    input  logic                    tx_valid,
    input  logic [BYTE_W-1:0]       tx_data,
    output logic                    tx_ready,
    output logic                    rx_valid,
    output logic [BYTE_W-1:0]       rx_data,
    output logic                    eng_req,
    output logic [2:0]              eng_op,
    output logic [BYTE_W-1:0]       eng_wbyte,
    output logic                    eng_mnack,
    input  logic                    eng_done,
    input  logic                    eng_ack,
    input  logic [BYTE_W-1:0]       eng_rbyte,
    output logic                    busy,
    output logic                    seq_done,
    output logic                    seq_err
);
    seq_state_t              state_q, nxt;
    eng_op_t                 op_q, op_n;
    logic                    phase_q, nxt_phase;
    logic                    addr_rd_q, nxt_rd;
    logic                    err_q, set_err;
    logic                    req_q, txr_q, rxv_q, done_q, mnack_q;
    logic [BYTE_W-1:0]       wbyte_q, rxd_q, byte_n, iadr_byte;
    logic                    mn_n, can, fin, bad, cur_rd;
    logic [ADDR_W-1:0]       s_addr;
    logic [IADR_BYTES*8-1:0] s_iadr;
    desc_t                   s_d0, s_d1;
    logic                    unused_pec;

    assign unused_pec = s_d0.pec ^ s_d1.pec ^ (|dcnt);

    // Internal address byte selected by remaining count, high byte first
    always_comb begin
        iadr_byte = '0;
        for (int b = 0; b < IADR_BYTES; b++)
            if (icnt == ISZ_W'(b + 1)) iadr_byte = s_iadr[b*8 +: 8];
    end

    // Handshake decode and counter controls
    always_comb begin
        fin    = req_q && eng_done;
        bad    = fin && !eng_ack && (op_q == OP_WRITE);
        cur_rd = phase_q ? s_d1.rd : s_d0.rd;
        go     = (state_q == ST_IDLE) && start_req && mode_en && (d0.len != '0);
        dload  = go;
        dval   = d0.len;
        ddec   = fin && (state_q == ST_DATA);
        idec   = fin && (state_q == ST_IADR);
        if (fin && state_q == ST_DATA && dlast && !phase_q && s_d1.len != '0 && !bad) begin
            dload = 1'b1;
            dval  = s_d1.len;
        end
    end

    // Next phase selection
    always_comb begin
        nxt       = state_q;
        nxt_phase = phase_q;
        nxt_rd    = addr_rd_q;
        set_err   = 1'b0;
        case (state_q)
            ST_IDLE:  if (go) nxt = ST_START;
            ST_START: if (fin) begin
                nxt    = ST_ADDR;
                nxt_rd = (icnt != '0) ? 1'b0 : s_d0.rd;
            end
            ST_ADDR: if (fin) begin
                if (bad)              begin nxt = ST_STOP; set_err = 1'b1; end
                else if (icnt != '0)  nxt = ST_IADR;
                else                  nxt = ST_DATA;
            end
            ST_IADR: if (fin) begin
                if (bad) begin
                    nxt = ST_STOP; set_err = 1'b1;
                end else if (ilast) begin
                    nxt    = s_d0.rd ? ST_RESTART : ST_DATA;
                    nxt_rd = s_d0.rd;
                end
            end
            ST_DATA: if (fin) begin
                if (bad) begin
                    nxt = ST_STOP; set_err = 1'b1;
                end else if (dlast) begin
                    if (!phase_q && s_d1.len != '0) begin
                        nxt       = ST_RESTART;
                        nxt_phase = 1'b1;
                        nxt_rd    = s_d1.rd;
                    end else begin
                        nxt = ST_STOP;
                    end
                end
            end
            ST_RESTART: if (fin) nxt = ST_ADDR;
            ST_STOP:    if (fin) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Operation to issue in the current phase
    always_comb begin
        op_n   = OP_STOP;
        byte_n = '0;
        mn_n   = 1'b0;
        can    = !req_q && (state_q != ST_IDLE);
        case (state_q)
            ST_START:   op_n = OP_START;
            ST_RESTART: op_n = OP_RESTART;
            ST_STOP:    op_n = OP_STOP;
            ST_ADDR: begin
                op_n   = OP_WRITE;
                byte_n = BYTE_W'({s_addr, addr_rd_q});
            end
            ST_IADR: begin
                op_n   = OP_WRITE;
                byte_n = iadr_byte;
            end
            ST_DATA: begin
                if (cur_rd) begin
                    op_n = OP_READ;
                    mn_n = dlast;
                end else begin
                    op_n   = OP_WRITE;
                    byte_n = tx_data;
                    can    = can && tx_valid;
                end
            end
            default: can = 1'b0;
        endcase
    end

    // Sequencer state, snapshot and engine handshake registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            phase_q   <= 1'b0;
            addr_rd_q <= 1'b0;
            err_q     <= 1'b0;
            req_q     <= 1'b0;
            op_q      <= OP_STOP;
            wbyte_q   <= '0;
            mnack_q   <= 1'b0;
            txr_q     <= 1'b0;
            rxv_q     <= 1'b0;
            rxd_q     <= '0;
            done_q    <= 1'b0;
            s_addr    <= '0;
            s_iadr    <= '0;
            s_d0      <= '0;
            s_d1      <= '0;
        end else begin
            txr_q     <= 1'b0;
            rxv_q     <= 1'b0;
            done_q    <= 1'b0;
            state_q   <= nxt;
            phase_q   <= nxt_phase;
            addr_rd_q <= nxt_rd;
            if (go) begin
                s_addr  <= slave_addr;
                s_iadr  <= iadr;
                s_d0    <= d0;
                s_d1    <= d1;
                err_q   <= 1'b0;
                phase_q <= 1'b0;
            end
            if (set_err) err_q <= 1'b1;
            if (fin) begin
                req_q <= 1'b0;
                if (state_q == ST_DATA && op_q == OP_READ) begin
                    rxv_q <= 1'b1;
                    rxd_q <= eng_rbyte;
                end
                if (state_q == ST_STOP) done_q <= 1'b1;
            end else if (can) begin
                req_q   <= 1'b1;
                op_q    <= op_n;
                wbyte_q <= byte_n;
                mnack_q <= mn_n;
                txr_q   <= (state_q == ST_DATA) && !cur_rd;
            end
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign eng_req   = req_q;
    assign eng_op    = op_q;
    assign eng_wbyte = wbyte_q;
    assign eng_mnack = mnack_q;
    assign tx_ready  = txr_q;
    assign rx_valid  = rxv_q;
    assign rx_data   = rxd_q;
    assign seq_done  = done_q;
    assign seq_err   = err_q;
endmodule

// File: rtl/i2c_cmd_seq.sv
// Top of the I2C command sequencer: register file, data and
// internal-address down-counters, and the phase controller.
// Assumes the bit engine handles all SCL/SDA timing.
module i2c_cmd_seq
    import i2c_cmd_seq_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int IADR_BYTES = 3,
    parameter int REG_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              eng_req,
    output logic [2:0]        eng_op,
    output logic [BYTE_W-1:0] eng_wbyte,
    output logic              eng_mnack,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic [BYTE_W-1:0] eng_rbyte,
    output logic              busy,
    output logic              seq_done,
    output logic              seq_err
);
    localparam int ISZ_W = $clog2(IADR_BYTES + 1);

    logic                    mode_en, start_req, go;
    logic [ADDR_W-1:0]       slave_addr;
    logic [ISZ_W-1:0]        iadr_size, icnt;
    logic [IADR_BYTES*8-1:0] iadr;
    desc_t                   d0, d1;
    logic                    dload, ddec, dlast, idec, ilast;
    logic [LEN_W-1:0]        dval, dcnt;

    i2c_cmd_seq_regs #(.ADDR_W(ADDR_W), .IADR_BYTES(IADR_BYTES), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .mode_en(mode_en), .start_req(start_req), .slave_addr(slave_addr),
        .iadr_size(iadr_size), .iadr(iadr), .d0(d0), .d1(d1)
    );

    i2c_cmd_seq_cnt #(.W(LEN_W)) u_dcnt (
        .clk(clk), .rst_n(rst_n), .load(dload), .load_val(dval), .dec(ddec),
        .count(dcnt), .last(dlast)
    );

    i2c_cmd_seq_cnt #(.W(ISZ_W)) u_icnt (
        .clk(clk), .rst_n(rst_n), .load(go), .load_val(iadr_size), .dec(idec),
        .count(icnt), .last(ilast)
    );

    i2c_cmd_seq_fsm #(.ADDR_W(ADDR_W), .IADR_BYTES(IADR_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .start_req(start_req),
        .slave_addr(slave_addr), .iadr(iadr), .d0(d0), .d1(d1),
        .dcnt(dcnt), .dlast(dlast), .icnt(icnt), .ilast(ilast),
        .go(go), .dload(dload), .dval(dval), .ddec(ddec), .idec(idec),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte), .eng_mnack(eng_mnack),
        .eng_done(eng_done), .eng_ack(eng_ack), .eng_rbyte(eng_rbyte),
        .busy(busy), .seq_done(seq_done), .seq_err(seq_err)
    );
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
// Protocol checker for the sequencer ports, bound to the top module.
// Assumes eng_done pulses only while eng_req is high.
module i2c_cmd_seq_chk
    import i2c_cmd_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       eng_req,
    input logic [2:0] eng_op,
    input logic [7:0] eng_wbyte,
    input logic       eng_done,
    input logic       eng_ack,
    input logic       busy,
    input logic       seq_done
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_req); // R1
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_wbyte)); // R12
    AST_TX_POP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> $past(tx_valid) && eng_req && eng_op == OP_WRITE); // R9
    AST_RX_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(eng_done && eng_req && eng_op == OP_READ)); // R10
    AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && eng_done && !eng_ack && eng_op == OP_WRITE |=> ##1 (eng_req && eng_op == OP_STOP)); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !busy && eng_op == OP_STOP); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done); // R11
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
    .eng_done(eng_done), .eng_ack(eng_ack), .busy(busy), .seq_done(seq_done)
);

// File: tb/i2c_cmd_seq_tb.sv
module i2c_cmd_seq_tb;
    import i2c_cmd_seq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        tx_valid = 1'b1;
    logic [7:0]  tx_data;
    logic        tx_ready, rx_valid, eng_req, eng_mnack, busy, seq_done, seq_err;
    logic [7:0]  rx_data, eng_wbyte;
    logic [2:0]  eng_op;
    logic        eng_done = 1'b0, eng_ack = 1'b1;
    logic [7:0]  eng_rbyte = '0;

    i2c_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte), .eng_mnack(eng_mnack),
        .eng_done(eng_done), .eng_ack(eng_ack), .eng_rbyte(eng_rbyte),
        .busy(busy), .seq_done(seq_done), .seq_err(seq_err)
    );

    int n_chk = 0, n_err = 0;

    // Observed transcript
    logic [2:0] g_op [0:1023];
    logic [7:0] g_byte [0:1023];
    logic       g_mn [0:1023];
    logic [7:0] g_rx [0:1023];
    int g_n = 0, g_rxn = 0, wr_idx = 0, rd_idx = 0, nack_at = -1, stab_bad = 0;
    int tx_idx = 0;
    logic [7:0] tx_base = '0;
    bit stall_en = 0;
    assign tx_data = tx_base + 8'(tx_idx);

    // Expected transcript
    logic [2:0] e_op [0:1023];
    logic [7:0] e_byte [0:1023];
    logic       e_mn [0:1023];
    int e_n, e_wr, e_tx, e_rx;
    bit e_halt, e_err;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Bit engine model
    initial begin
        forever begin
            @(negedge clk);
            if (eng_req) begin
                logic [2:0] op0;
                logic [7:0] b0;
                op0 = eng_op; b0 = eng_wbyte;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                if (eng_op != op0 || eng_wbyte != b0 || !eng_req) stab_bad++;
                g_op[g_n] = eng_op; g_byte[g_n] = eng_wbyte; g_mn[g_n] = eng_mnack;
                g_n++;
                eng_ack = 1'b1;
                if (eng_op == OP_WRITE) begin
                    if (wr_idx == nack_at) eng_ack = 1'b0;
                    wr_idx++;
                end
                if (eng_op == OP_READ) begin
                    eng_rbyte = 8'h5A ^ 8'(rd_idx);
                    rd_idx++;
                end
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
            end
        end
    end

    // Stream monitors
    initial begin
        forever begin
            @(negedge clk);
            if (tx_ready) tx_idx++;
            if (rx_valid) begin g_rx[g_rxn] = rx_data; g_rxn++; end
            tx_valid = stall_en ? 1'($urandom_range(0, 1)) : 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic epush(input logic [2:0] op, input logic [7:0] b, input logic mn, input bit is_data);
        if (!e_halt) begin
            e_op[e_n] = op; e_mn[e_n] = mn;
            e_byte[e_n] = is_data ? (tx_base + 8'(e_tx)) : b;
            e_n++;
            if (is_data) e_tx++;
            if (op == OP_READ) e_rx++;
            if (op == OP_WRITE) begin
                if (e_wr == nack_at) begin
                    e_halt = 1; e_err = 1;
                    e_op[e_n] = OP_STOP; e_mn[e_n] = 0; e_byte[e_n] = 0; e_n++;
                end
                e_wr++;
            end
        end
    endtask

    task automatic edata(input int len, input bit rd);
        for (int i = 0; i < len; i++)
            if (rd) epush(OP_READ, 8'h00, (i == len - 1), 0);
            else    epush(OP_WRITE, 8'h00, 0, 1);
    endtask

    task automatic reset_obs();
        g_n = 0; g_rxn = 0; wr_idx = 0; rd_idx = 0; tx_idx = 0; stab_bad = 0;
    endtask

    task automatic run_case(input string tag, input logic [6:0] addr, input int isz, input logic [23:0] iadr,
                            input int len0, input bit rd0, input bit pec0,
                            input int len1, input bit rd1, input bit pec1,
                            input bit rdflag, input int nk, input bit stall);
        int bad, first, waitc;
        bit seen;
        reset_obs();
        nack_at = nk; stall_en = stall; tx_base = 8'($urandom_range(0, 255));
        e_n = 0; e_wr = 0; e_tx = 0; e_rx = 0; e_halt = 0; e_err = 0;
        epush(OP_START, 0, 0, 0);
        if (isz > 0) begin
            epush(OP_WRITE, {addr, 1'b0}, 0, 0);
            for (int k = isz - 1; k >= 0; k--) epush(OP_WRITE, iadr[k*8 +: 8], 0, 0);
            if (rd0) begin epush(OP_RESTART, 0, 0, 0); epush(OP_WRITE, {addr, 1'b1}, 0, 0); end
        end else begin
            epush(OP_WRITE, {addr, rd0}, 0, 0);
        end
        edata(len0, rd0);
        if (len1 != 0) begin
            epush(OP_RESTART, 0, 0, 0);
            epush(OP_WRITE, {addr, rd1}, 0, 0);
            edata(len1, rd1);
        end
        epush(OP_STOP, 0, 0, 0);

        wr(SEL_MODE, 32'(addr) | (32'(isz) << 8) | (32'(rdflag) << 12));
        wr(SEL_IADR, 32'(iadr));
        wr(SEL_CMD, 32'(len0) | (32'(rd0) << 8) | (32'(pec0) << 9) |
                    (32'(len1) << 16) | (32'(rd1) << 24) | (32'(pec1) << 25));
        wr(SEL_CTRL, 32'h1);
        seen = 0; waitc = 0;
        while (!seen && waitc < 20000) begin
            @(negedge clk);
            if (seq_done) seen = 1;
            waitc++;
        end
        chk(seen, tag, "sequence done pulse seen", seen, 1);
        chk(!busy, "R11", "busy low after done", busy, 0);
        chk(g_n == e_n, tag, "operation count", g_n, e_n);
        bad = 0; first = -1;
        for (int i = 0; i < e_n && i < g_n; i++) begin
            if (g_op[i] != e_op[i] ||
                (e_op[i] == OP_WRITE && g_byte[i] != e_byte[i]) ||
                (e_op[i] == OP_READ && g_mn[i] != e_mn[i])) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first >= 0)
            chk(0, tag, $sformatf("op %0d code/byte/nack", first),
                int'({g_op[first], g_byte[first], g_mn[first]}), int'({e_op[first], e_byte[first], e_mn[first]}));
        else chk(1, tag, "operation sequence", 0, 0);
        chk(seq_err == e_err, "R7", "error flag", seq_err, e_err);
        chk(tx_idx == e_tx, "R9", "transmit bytes taken", tx_idx, e_tx);
        bad = (g_rxn != e_rx) ? 1 : 0;
        for (int i = 0; i < g_rxn && i < e_rx; i++)
            if (g_rx[i] != (8'h5A ^ 8'(i))) bad++;
        chk(bad == 0, "R10", "received bytes count/order", g_rxn, e_rx);
        chk(stab_bad == 0, "R12", "request stable while pending", stab_bad, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic ignored_start(input string what);
        reset_obs();
        wr(SEL_CTRL, 32'h1);
        repeat (20) @(negedge clk);
        chk(!busy && g_n == 0, "R1", what, g_n, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!busy && !eng_req && !seq_err && !seq_done && !tx_ready && !rx_valid,
            "R11", "outputs quiet during reset", int'(busy), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !eng_req && !seq_err, "R11", "idle after reset", int'(eng_req), 0);

        // R1: mode disabled, then zero first length
        wr(SEL_CMD, 32'h3);
        ignored_start("start ignored while mode disabled");
        wr(SEL_CTRL, 32'h1_0000);
        wr(SEL_CMD, 32'h0);
        ignored_start("start ignored with zero first length");
        wr(SEL_CTRL, 32'h3_0000);
        wr(SEL_CMD, 32'h3);
        ignored_start("disable wins over enable");
        wr(SEL_CTRL, 32'h1_0000);

        run_case("R2", 7'h50, 0, 0, 3, 0, 0, 0, 0, 0, 0, -1, 0);
        run_case("R6", 7'h21, 0, 0, 1, 1, 0, 0, 0, 0, 0, -1, 0);
        run_case("R6", 7'h22, 0, 0, 5, 1, 0, 0, 0, 0, 0, -1, 0);
        run_case("R4", 7'h51, 2, 24'h00_ABCD, 4, 1, 0, 0, 0, 0, 0, -1, 0);
        run_case("R4", 7'h52, 3, 24'h12_3456, 2, 0, 0, 0, 0, 0, 0, -1, 0);
        run_case("R4", 7'h53, 1, 24'h00_0077, 3, 1, 0, 0, 0, 0, 0, -1, 0);
        run_case("R3", 7'h30, 0, 0, 2, 0, 0, 3, 1, 0, 0, -1, 0);
        run_case("R3", 7'h31, 2, 24'h00_0102, 2, 1, 0, 2, 0, 0, 0, -1, 0);
        run_case("R5", 7'h40, 0, 0, 3, 0, 0, 0, 0, 0, 1, -1, 0);
        run_case("R5", 7'h41, 0, 0, 2, 1, 0, 1, 0, 0, 1, -1, 0);
        run_case("R8", 7'h42, 1, 24'h00_0009, 2, 0, 1, 2, 1, 1, 0, -1, 0);
        run_case("R7", 7'h60, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0);
        run_case("R7", 7'h61, 3, 24'hAA_BBCC, 3, 1, 0, 0, 0, 0, 0, 2, 0);
        run_case("R7", 7'h62, 0, 0, 4, 0, 0, 0, 0, 0, 0, 2, 0);
        run_case("R7", 7'h63, 0, 0, 2, 0, 0, 2, 1, 0, 0, 3, 0);
        run_case("R9", 7'h70, 0, 0, 6, 0, 0, 4, 0, 0, 0, -1, 1);
        run_case("R2", 7'h71, 0, 0, 255, 1, 0, 0, 0, 0, 0, -1, 0);
        run_case("R2", 7'h72, 0, 0, 255, 0, 0, 1, 0, 0, 0, -1, 0);

        for (int n = 0; n < 30; n++) begin
            int l1;
            l1 = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, 6));
            run_case("R2", 7'($urandom_range(0, 127)), int'($urandom_range(0, 3)),
                     24'($urandom), int'($urandom_range(1, 8)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), l1, 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 6)) : -1,
                     1'($urandom_range(0, 1)));
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule